// File: doc/BRIEF.md
# Address Issue Rate and Outstanding Regulator

This block sits on a single address channel (write or read) between a master and an interconnect, and throttles how quickly addresses may be issued. Two limits apply. The first is a cap on how many transactions may be in flight at once. The second is a peak-rate limit: the spacing in cycles between transactions, with a small allowance for bursts. A separate enable bit turns each limit on or off. When both bits are clear, the channel passes straight through in the same cycle.

The peak-rate limit uses a token counter. Tokens accrue at a fixed interval and are held up to a programmable ceiling, and each issued address spends one token. The in-flight count goes up on each address handshake and down on each completion pulse. The completion pulse is a write response, or the last beat of a read. While a limit holds the channel, the block drops valid toward the interconnect and ready toward the master. The master therefore keeps its address until the block lets it through.

Top module: `addr_issue_regulator`

## Requirements
- R1: With both enables clear, `down_valid` equals `up_valid`, `up_ready` equals `down_ready`, and `down_payload` equals `up_payload` in the same cycle.
- R2: With `cfg_ot_en` set and the in-flight count at or above `cfg_max_ot`, both `down_valid` and `up_ready` are low. A cap of 0 blocks every address.
- R3: The in-flight count rises by one on each handshake (`up_valid && up_ready`) and falls by one on each `cpl_valid` cycle. A handshake and a completion in the same cycle leave it unchanged. A completion with nothing in flight is ignored. Counting continues while `cfg_ot_en` is clear.
- R4: One token accrues every `cfg_cycles` cycles, and a value of 0 counts as 1. With `cfg_rate_en` set and no token held, both `down_valid` and `up_ready` are low.
- R5: Tokens saturate at `cfg_burst`, and a value of 0 counts as 1. With a ceiling of 1 and a steady demand, handshakes occur exactly `cfg_cycles` cycles apart. After an idle stretch with a ceiling of B, B handshakes go back to back.
- R6: Reset leaves one token held, nothing in flight and the interval counter at zero. The first address after reset can therefore issue at once with both limits enabled.
- R7: A held address is not lost. It issues with its payload intact as soon as both enabled limits allow it.
- R8: A change to any configuration input acts from the next clock edge's cycle. The in-flight count is kept across the change.
- R9: While `cfg_rate_en` is clear, handshakes spend no tokens but tokens keep accruing. Enabling rate control after a long stretch of traffic therefore admits a full burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rate_en | input | 1 | Enable peak-rate control |
| cfg_ot_en | input | 1 | Enable in-flight cap |
| cfg_max_ot | input | OT_W | In-flight cap |
| cfg_cycles | input | CYC_W | Cycles per token |
| cfg_burst | input | TOK_W | Token ceiling (burst allowance) |
| up_valid | input | 1 | Address valid from master |
| up_ready | output | 1 | Address ready to master |
| up_payload | input | PAYLOAD_W | Address and attributes from master |
| down_valid | output | 1 | Address valid to interconnect |
| down_ready | input | 1 | Address ready from interconnect |
| down_payload | output | PAYLOAD_W | Address and attributes to interconnect |
| cpl_valid | input | 1 | One-cycle completion pulse |

## Verification
The bound assertions check on every cycle the properties that hold at each clock edge. These are: the in-flight cap and the empty-token hold both force the outputs low, the pass-through equality holds when both enables are clear, the in-flight count steps by exactly one or stays put, and tokens never exceed a stable ceiling. Some behaviours only the bench scenarios can show, because each depends on a history of many cycles. These are the exact spacing of issues under a given cycle setting, the back-to-back burst after idle time, tokens built up while rate control is off, and the reaction to a cap raised or lowered against a live count.

// File: rtl/air_pkg.sv
package air_pkg;
  typedef enum logic [1:0] {
    GATE_OPEN      = 2'd0,
    GATE_OT_HOLD   = 2'd1,
    GATE_RATE_HOLD = 2'd2,
    GATE_BOTH_HOLD = 2'd3
  } gate_state_e;
endpackage

// File: rtl/air_token_bucket.sv
module air_token_bucket #(
  parameter int CYC_W = 8,
  parameter int TOK_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CYC_W-1:0] cfg_cycles,
  input  logic [TOK_W-1:0] cfg_burst,
  input  logic             consume,
  output logic [TOK_W-1:0] tokens,
  output logic             has_token
);
  localparam logic [CYC_W-1:0] CYC_ONE = CYC_W'(1);
  localparam logic [TOK_W-1:0] TOK_ONE = TOK_W'(1);

  logic [CYC_W-1:0] div_q, div_d, eff_cycles;
  logic [TOK_W-1:0] tok_q, tok_d, eff_burst;
  logic [TOK_W:0]   sum;
  logic             tick;

  always_comb begin
    eff_cycles = (cfg_cycles == '0) ? CYC_ONE : cfg_cycles;
    eff_burst  = (cfg_burst == '0) ? TOK_ONE : cfg_burst;
    tick       = (div_q >= (eff_cycles - CYC_ONE));
    div_d      = tick ? '0 : (div_q + CYC_ONE);
    sum        = {1'b0, tok_q} + {{TOK_W{1'b0}}, tick} - {{TOK_W{1'b0}}, consume};
    if (sum > {1'b0, eff_burst}) tok_d = eff_burst;
    else                         tok_d = sum[TOK_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      tok_q <= TOK_ONE;
    end else begin
      div_q <= div_d;
      tok_q <= tok_d;
    end
  end

  assign tokens    = tok_q;
  assign has_token = (tok_q != '0);
endmodule

// File: rtl/air_ot_counter.sv
module air_ot_counter #(
  parameter int OT_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  input  logic            dec,
  output logic [OT_W-1:0] count
);
  localparam logic [OT_W-1:0] OT_ONE = OT_W'(1);
  localparam logic [OT_W-1:0] OT_TOP = {OT_W{1'b1}};

  logic [OT_W-1:0] cnt_q, cnt_d;
  logic            dec_ok;

  always_comb begin
    dec_ok = dec && ((cnt_q != '0) || inc);
    cnt_d  = cnt_q;
    if (inc && !dec_ok) begin
      if (cnt_q != OT_TOP) cnt_d = cnt_q + OT_ONE;
    end else if (dec_ok && !inc) begin
      cnt_d = cnt_q - OT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/air_gate.sv
module air_gate #(
  parameter int OT_W = 5
) (
  input  logic                  rate_en,
  input  logic                  ot_en,
  input  logic                  has_token,
  input  logic [OT_W-1:0]       ot_count,
  input  logic [OT_W-1:0]       max_ot,
  input  logic                  up_valid,
  input  logic                  down_ready,
  output logic                  down_valid,
  output logic                  up_ready,
  output logic                  handshake,
  output air_pkg::gate_state_e  state
);
  import air_pkg::*;
  logic ot_hold, rate_hold, open_g;

  always_comb begin
    ot_hold   = ot_en && (ot_count >= max_ot);
    rate_hold = rate_en && !has_token;
    case ({rate_hold, ot_hold})
      2'b00:   state = GATE_OPEN;
      2'b01:   state = GATE_OT_HOLD;
      2'b10:   state = GATE_RATE_HOLD;
      default: state = GATE_BOTH_HOLD;
    endcase
    open_g     = (state == GATE_OPEN);
    down_valid = up_valid && open_g;
    up_ready   = down_ready && open_g;
    handshake  = up_valid && down_ready && open_g;
  end
endmodule

// File: rtl/addr_issue_regulator.sv
module addr_issue_regulator #(
  parameter int PAYLOAD_W = 40,
  parameter int OT_W      = 5,
  parameter int CYC_W     = 8,
  parameter int TOK_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_rate_en,
  input  logic                 cfg_ot_en,
  input  logic [OT_W-1:0]      cfg_max_ot,
  input  logic [CYC_W-1:0]     cfg_cycles,
  input  logic [TOK_W-1:0]     cfg_burst,
  input  logic                 up_valid,
  output logic                 up_ready,
  input  logic [PAYLOAD_W-1:0] up_payload,
  output logic                 down_valid,
  input  logic                 down_ready,
  output logic [PAYLOAD_W-1:0] down_payload,
  input  logic                 cpl_valid
);
  import air_pkg::*;

  logic [TOK_W-1:0] tokens;
  logic [OT_W-1:0]  ot_count;
  logic             has_token, handshake;
  gate_state_e      gate_state;

  air_token_bucket #(.CYC_W(CYC_W), .TOK_W(TOK_W)) bucket_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_cycles (cfg_cycles),
    .cfg_burst  (cfg_burst),
    .consume    (handshake && cfg_rate_en),
    .tokens     (tokens),
    .has_token  (has_token)
  );

  air_ot_counter #(.OT_W(OT_W)) ot_i (
    .clk   (clk),
    .rst   (rst),
    .inc   (handshake),
    .dec   (cpl_valid),
    .count (ot_count)
  );

  air_gate #(.OT_W(OT_W)) gate_i (
    .rate_en    (cfg_rate_en),
    .ot_en      (cfg_ot_en),
    .has_token  (has_token),
    .ot_count   (ot_count),
    .max_ot     (cfg_max_ot),
    .up_valid   (up_valid),
    .down_ready (down_ready),
    .down_valid (down_valid),
    .up_ready   (up_ready),
    .handshake  (handshake),
    .state      (gate_state)
  );

  assign down_payload = up_payload;
endmodule

// File: rtl/addr_issue_regulator_chk.sv
module addr_issue_regulator_chk #(
  parameter int PAYLOAD_W = 40,
  parameter int OT_W      = 5,
  parameter int TOK_W     = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_rate_en,
  input logic                 cfg_ot_en,
  input logic [OT_W-1:0]      cfg_max_ot,
  input logic [TOK_W-1:0]     cfg_burst,
  input logic                 up_valid,
  input logic                 up_ready,
  input logic [PAYLOAD_W-1:0] up_payload,
  input logic                 down_valid,
  input logic                 down_ready,
  input logic [PAYLOAD_W-1:0] down_payload,
  input logic                 cpl_valid,
  input logic [OT_W-1:0]      ot_count,
  input logic [TOK_W-1:0]     tokens
);
  logic hs;
  assign hs = up_valid && up_ready;

  assert_passthru_R1: assert property (@(posedge clk) disable iff (rst)
    (!cfg_rate_en && !cfg_ot_en) |-> (down_valid == up_valid && up_ready == down_ready && down_payload == up_payload));

  assert_ot_cap_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_ot_en && ot_count >= cfg_max_ot) |-> (!down_valid && !up_ready));

  assert_ot_inc_R3: assert property (@(posedge clk) disable iff (rst)
    (hs && !cpl_valid && ot_count != {OT_W{1'b1}}) |=> (ot_count == $past(ot_count) + OT_W'(1)));

  assert_ot_same_R3: assert property (@(posedge clk) disable iff (rst)
    (hs && cpl_valid) |=> $stable(ot_count));

  assert_ot_dec_R3: assert property (@(posedge clk) disable iff (rst)
    (!hs && cpl_valid && ot_count != '0) |=> (ot_count == $past(ot_count) - OT_W'(1)));

  assert_rate_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_rate_en && tokens == '0) |-> (!down_valid && !up_ready));

  assert_tok_ceiling_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_burst != '0 && $stable(cfg_burst)) |-> (tokens <= cfg_burst));

  assert_hold_consistent_R7: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_ready) |-> (down_valid && down_ready));
endmodule

bind addr_issue_regulator addr_issue_regulator_chk #(
  .PAYLOAD_W(PAYLOAD_W), .OT_W(OT_W), .TOK_W(TOK_W)
) chk_i (
  .clk(clk), .rst(rst), .cfg_rate_en(cfg_rate_en), .cfg_ot_en(cfg_ot_en),
  .cfg_max_ot(cfg_max_ot), .cfg_burst(cfg_burst), .up_valid(up_valid),
  .up_ready(up_ready), .up_payload(up_payload), .down_valid(down_valid),
  .down_ready(down_ready), .down_payload(down_payload), .cpl_valid(cpl_valid),
  .ot_count(ot_count), .tokens(tokens)
);

// File: tb/addr_issue_regulator_tb_top.sv
module addr_issue_regulator_tb_top;
  localparam int PW = 40;
  localparam int OW = 5;
  localparam int CW = 8;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_rate_en = 1'b0, cfg_ot_en = 1'b0;
  logic [OW-1:0] cfg_max_ot = '0;
  logic [CW-1:0] cfg_cycles = '0;
  logic [TW-1:0] cfg_burst = '0;
  logic up_valid = 1'b0, down_ready = 1'b0, cpl_valid = 1'b0;
  logic [PW-1:0] up_payload = '0;
  logic up_ready, down_valid;
  logic [PW-1:0] down_payload;

  int total = 0, bad = 0;
  bit done = 0;
  int m_tok, m_div, m_ot;

  always #4 clk = ~clk;

  addr_issue_regulator #(.PAYLOAD_W(PW), .OT_W(OW), .CYC_W(CW), .TOK_W(TW)) dut_i (
    .clk(clk), .rst(rst), .cfg_rate_en(cfg_rate_en), .cfg_ot_en(cfg_ot_en),
    .cfg_max_ot(cfg_max_ot), .cfg_cycles(cfg_cycles), .cfg_burst(cfg_burst),
    .up_valid(up_valid), .up_ready(up_ready), .up_payload(up_payload),
    .down_valid(down_valid), .down_ready(down_ready), .down_payload(down_payload),
    .cpl_valid(cpl_valid)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_allow();
    bit ot_ok, rt_ok;
    ot_ok = !cfg_ot_en || (m_ot < int'(cfg_max_ot));
    rt_ok = !cfg_rate_en || (m_tok != 0);
    return ot_ok && rt_ok;
  endfunction

  function automatic void model_reset();
    m_tok = 1; m_div = 0; m_ot = 0;
  endfunction

  function automatic void model_update(input bit hs, input bit cpl);
    int ec, eb, sum;
    bit tick, dec;
    ec = (cfg_cycles == 0) ? 1 : int'(cfg_cycles);
    eb = (cfg_burst == 0) ? 1 : int'(cfg_burst);
    tick = (m_div >= ec - 1);
    m_div = tick ? 0 : m_div + 1;
    sum = m_tok + int'(tick) - int'(hs && cfg_rate_en);
    m_tok = (sum > eb) ? eb : sum;
    dec = cpl && (m_ot != 0 || hs);
    if (hs && !dec) begin
      if (m_ot != (1 << OW) - 1) m_ot++;
    end else if (dec && !hs) m_ot--;
  endfunction

  task automatic step(input bit uv, input bit dr, input bit cpl, input logic [PW-1:0] pl, output bit hs);
    bit ea;
    string tag;
    up_valid = uv; down_ready = dr; cpl_valid = cpl; up_payload = pl;
    #1;
    ea = model_allow();
    if (!ea && cfg_ot_en && m_ot >= int'(cfg_max_ot)) tag = "R2";
    else if (!ea) tag = "R4";
    else if (cfg_ot_en || cfg_rate_en) tag = "R7";
    else tag = "R1";
    check(down_valid === (uv && ea), {tag, " down_valid"}, longint'(down_valid), longint'(uv && ea));
    check(up_ready === (dr && ea), {tag, " up_ready"}, longint'(up_ready), longint'(dr && ea));
    check(down_payload === pl, "R1 payload", longint'(down_payload), longint'(pl));
    hs = uv && dr && ea;
    @(posedge clk);
    model_update(hs, cpl);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit hs;
    int hs_at[16];
    int nhs;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R6: first address issues at once with both limits on
    cfg_rate_en = 1; cfg_ot_en = 1; cfg_max_ot = 1; cfg_cycles = 4; cfg_burst = 2;
    up_valid = 1; down_ready = 1; #1;
    check(down_valid === 1'b1, "R6 reset token", longint'(down_valid), 1);
    step(1, 1, 0, 40'h11, hs);
    check(hs == 1, "R6 first issue", longint'(hs), 1);
    step(1, 1, 1, 40'h12, hs);
    check(hs == 0, "R2 cap of one holds", longint'(hs), 0);

    // R5: spacing with ceiling 1
    cfg_ot_en = 0; cfg_cycles = 5; cfg_burst = 1; nhs = 0;
    for (int i = 0; i < 60; i++) begin
      step(1, 1, 0, PW'(i), hs);
      if (hs && nhs < 16) begin hs_at[nhs] = i; nhs++; end
    end
    for (int k = 2; k < nhs; k++)
      check(hs_at[k] - hs_at[k-1] == 5, "R5 spacing", hs_at[k] - hs_at[k-1], 5);
    check(nhs >= 10, "R5 issue count", nhs, 11);

    // R5: burst after idle
    cfg_burst = 4; cfg_cycles = 3;
    for (int i = 0; i < 15; i++) step(0, 1, 0, '0, hs);
    for (int i = 0; i < 4; i++) begin
      step(1, 1, 0, PW'(100 + i), hs);
      check(hs == 1, "R5 back-to-back", longint'(hs), 1);
    end

    // R9: tokens accrue while rate control off
    cfg_rate_en = 0; cfg_burst = 3; cfg_cycles = 7;
    for (int i = 0; i < 30; i++) step(1, 1, 0, PW'(i), hs);
    cfg_rate_en = 1;
    for (int i = 0; i < 3; i++) begin
      step(1, 1, 0, PW'(200 + i), hs);
      check(hs == 1, "R9 full burst", longint'(hs), 1);
    end

    // R3 / R8: in-flight accounting
    cfg_rate_en = 0; cfg_ot_en = 1; cfg_max_ot = 3;
    for (int i = 0; i < 40; i++) step(0, 0, 1, '0, hs);
    step(1, 1, 0, 40'h1, hs); step(1, 1, 0, 40'h2, hs);
    step(1, 1, 1, 40'h3, hs);
    check(hs == 1, "R3 issue with completion", longint'(hs), 1);
    step(1, 1, 0, 40'h4, hs);
    check(hs == 1, "R3 count two after pair", longint'(hs), 1);
    step(1, 1, 0, 40'h5, hs);
    check(hs == 0, "R3 cap reached", longint'(hs), 0);
    cfg_max_ot = 4;
    step(1, 1, 0, 40'h5, hs);
    check(hs == 1, "R8 raised cap", longint'(hs), 1);
    cfg_max_ot = 2;
    step(1, 1, 1, 40'h6, hs);
    check(hs == 0, "R8 lowered cap", longint'(hs), 0);
    step(1, 0, 1, 40'h6, hs);
    check(down_valid == 0, "R8 still held at two", longint'(down_valid), 0);
    step(0, 0, 1, '0, hs);
    step(1, 1, 0, 40'h6, hs);
    check(hs == 1, "R7 held address issues", longint'(hs), 1);

    // random mix
    for (int i = 0; i < 5000; i++) begin
      if ($urandom_range(0, 49) == 0) begin
        cfg_rate_en = 1'($urandom);
        cfg_ot_en   = 1'($urandom);
        cfg_cycles  = CW'($urandom_range(0, 6));
        cfg_burst   = TW'($urandom_range(0, 5));
        cfg_max_ot  = OW'($urandom_range(0, 6));
      end
      step($urandom_range(0, 9) < 7, $urandom_range(0, 9) < 7,
           $urandom_range(0, 2) == 0, {$urandom, $urandom}, hs);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule